// File: doc/BRIEF.md
# OFDM Null-Symbol and Symbol-Timing Detector

This block sits behind a rectangular-to-polar converter in an OFDM receiver. It takes one polar sample per valid strobe, a 16-bit magnitude and an 8-bit coarse phase, and produces two sliding-window statistics. The first is the mean magnitude over one symbol period, reported as a 16-bit signal-strength value. The second is the mean absolute phase change between each sample and the sample one FFT length earlier, taken over a window as long as the cyclic prefix. It is reported as a 12-bit value with four fractional bits.

The magnitude average dips during a null symbol. The block tracks its lowest value and raises a sticky start flag once the lowest value has stayed unbeaten for a programmable number of samples. The phase-lag statistic falls to its lowest value where the cyclic prefix repeats the tail of the symbol. The block tracks that minimum in the same way and raises a sticky sync flag once it has held for one cyclic-prefix length. A carrier-detect output compares the magnitude average with a threshold. An init pulse re-arms both trackers for the next symbol.

Every window length is a power of two. Each window is held as a running sum plus a circular history. Two write-strobed 16-bit words set the window sizes and the start delay.

Top module: `ofdm_sync_detect`

## Requirements
- R1: Let S be the symbol-size field and n the number of samples accepted since the last configuration write. In the cycle after an accepted sample, `rssi_o` equals the sum of the latest min(n, 2^S) magnitudes shifted right by S. `rssi_o` changes only after an accepted sample or a configuration write.
- R2: Let F be the FFT-size field. The phase step of a sample is (phase − phase of the sample 2^F accepted samples earlier) mod 256, read as an 8-bit two's-complement value. Its absolute value is used, and 0x80 counts as 128. A step exists only once 2^F samples have been accepted since the last configuration write.
- R3: Let C be the prefix-size field and m the number of phase steps since the last configuration write. `phcor_o` equals ((sum of the latest min(m, 2^C) steps) × 16) >> C, truncated to 12 bits.
- R4: `dcd_o` is high exactly when at least 2^S samples have been accepted since the last configuration write and `rssi_o` ≥ `min_amp_i`.
- R5: While the magnitude window is full, each average is evaluated one cycle after it appears. A value below the tracked minimum becomes the new minimum and loads the start delay D. `start_o` is set on the (D+1)-th evaluated average after the newest minimum that does not improve on it, and stays set until cleared.
- R6: The same rule applies to `phcor_o` while its window is full (at least 2^C steps). The delay is 2^C − 1, so `sync_o` is set on the 2^C-th non-improving value after the newest minimum. It stays set until cleared.
- R7: An `init_i` pulse resets both tracked minima and clears `start_o` and `sync_o` in the next cycle. It leaves the running sums unchanged.
- R8: `cfg_we_i[0]` loads word A, with the prefix size in bits [7:0] and the FFT size in bits [15:8]. `cfg_we_i[1]` loads word B, with the symbol size in bits [7:0] and the start delay in bits [15:8]. Size values above 6 are stored as 6. A write empties both windows, resets the trackers and flags, and discards any sample arriving in the same cycle.
- R9: After reset, all outputs are zero and the configuration is S=5, C=2, F=4, D=0.
- R10: `vld_o` is high exactly in the cycle after an accepted sample, that is, `vld_i` high with no configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mag_i | input | 16 | Sample magnitude, unsigned |
| phs_i | input | 8 | Sample phase, upper bits of a full-circle phase |
| vld_i | input | 1 | Sample strobe |
| init_i | input | 1 | Re-arm minimum trackers and clear flags |
| cfg_data_i | input | 16 | Configuration word |
| cfg_we_i | input | 2 | Write strobes: bit 0 word A, bit 1 word B |
| min_amp_i | input | 16 | Carrier-detect threshold |
| rssi_o | output | 16 | Symbol-length magnitude average |
| phcor_o | output | 12 | Prefix-length mean phase step, 4 fractional bits |
| vld_o | output | 1 | Outputs updated by a sample |
| start_o | output | 1 | Null-symbol minimum found (sticky) |
| sync_o | output | 1 | Timing minimum found (sticky) |
| dcd_o | output | 1 | Carrier above threshold |

## Verification
The checker watches several properties on every cycle: the one-cycle valid delay, that both averages hold still when no sample or write arrives, that carrier detect never exceeds its threshold, that init and configuration writes clear the flags, and that a flag can only rise right after a sample update. The exact window sums, the wrap-around of phase steps, the size clamping and the count of non-improving samples before each flag can only be shown by the bench scenarios. The bench compares every sample against a model of the window arithmetic and of the minimum trackers.

// File: rtl/ofdm_sync_pkg.sv
package ofdm_sync_pkg;

    localparam int MAG_W_D   = 16;
    localparam int PHS_W_D   = 8;
    localparam int COR_W_D   = 12;
    localparam int COR_FRAC  = 4;
    localparam int LOG_MAX_D = 6;
    localparam int FLD_W     = 8;

    // Configuration word A: window sizes used by the phase path
    typedef struct packed {
        logic [FLD_W-1:0] fft_log;
        logic [FLD_W-1:0] cp_log;
    } win_cfg_t;

    // Configuration word B: symbol window and start delay
    typedef struct packed {
        logic [FLD_W-1:0] sof_dly;
        logic [FLD_W-1:0] sym_log;
    } frm_cfg_t;

    function automatic logic [FLD_W-1:0] clamp_log(input logic [FLD_W-1:0] v,
                                                   input int unsigned lim);
        return (v > FLD_W'(lim)) ? FLD_W'(lim) : v;
    endfunction

endpackage

// File: rtl/ofdm_dly_line.sv
// Circular history: returns the sample written `lag` strobes ago and
// whether that many samples have arrived since the last clear.
module ofdm_dly_line #(
    parameter int W     = 16,
    parameter int LOG_D = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           en,
    input  logic [W-1:0]   din,
    input  logic [LOG_D:0] lag,
    output logic [W-1:0]   dout,
    output logic           ready
);
    localparam int DEPTH = 1 << LOG_D;

    logic [W-1:0]     mem [DEPTH];
    logic [LOG_D-1:0] wptr;
    logic [LOG_D-1:0] rptr;
    logic [LOG_D:0]   fill;

    assign rptr  = wptr - lag[LOG_D-1:0];
    assign dout  = mem[rptr];
    assign ready = (fill >= lag);

    always_ff @(posedge clk) begin
        if (rst)     wptr <= '0;
        else if (en) wptr <= wptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            fill <= '0;
        else if (en && (fill != (LOG_D+1)'(DEPTH)))
            fill <= fill + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (en) mem[wptr] <= din;
    end
endmodule

// File: rtl/ofdm_win_avg.sv
// Power-of-two moving average: running sum plus history, shift to scale.
module ofdm_win_avg #(
    parameter int W       = 16,
    parameter int LOG_MAX = 6,
    parameter int LW      = 8,
    parameter int FRAC    = 0,
    parameter int OUT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [W-1:0]     x,
    input  logic [LW-1:0]    log_len,
    output logic [OUT_W-1:0] avg,
    output logic             full
);
    localparam int SUM_W = W + LOG_MAX;
    localparam int SC_W  = SUM_W + FRAC;

    logic [LOG_MAX:0] len;
    logic [W-1:0]     old;
    logic [SUM_W-1:0] sum_q;
    logic [SC_W-1:0]  scaled;

    assign len = (LOG_MAX+1)'(1) << log_len;

    ofdm_dly_line #(.W(W), .LOG_D(LOG_MAX)) u_hist (
        .clk(clk), .rst(rst), .clr(clr), .en(en),
        .din(x), .lag(len), .dout(old), .ready(full)
    );

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_q <= '0;
        else if (en)
            sum_q <= sum_q + SUM_W'(x) - (full ? SUM_W'(old) : '0);
    end

    assign scaled = (SC_W'(sum_q) << FRAC) >> log_len;
    assign avg    = OUT_W'(scaled);
endmodule

// File: rtl/ofdm_min_hold.sv
// Tracks the lowest evaluated value; sets a sticky flag once the minimum
// has gone unbeaten for hold+1 further evaluations.
module ofdm_min_hold #(
    parameter int VW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          eval,
    input  logic [VW-1:0] val,
    input  logic [CW-1:0] hold,
    output logic          flag
);
    logic [VW-1:0] min_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            min_q   <= '1;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            flag    <= 1'b0;
        end else if (eval) begin
            if (val < min_q) begin
                min_q   <= val;
                cnt_q   <= hold;
                armed_q <= 1'b1;
            end else if (armed_q) begin
                if (cnt_q == '0) begin
                    flag    <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ofdm_sync_detect.sv
module ofdm_sync_detect
    import ofdm_sync_pkg::*;
#(
    parameter int MAG_W   = MAG_W_D,
    parameter int PHS_W   = PHS_W_D,
    parameter int COR_W   = COR_W_D,
    parameter int LOG_MAX = LOG_MAX_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [PHS_W-1:0] phs_i,
    input  logic             vld_i,
    input  logic             init_i,
    input  logic [15:0]      cfg_data_i,
    input  logic [1:0]       cfg_we_i,
    input  logic [MAG_W-1:0] min_amp_i,
    output logic [MAG_W-1:0] rssi_o,
    output logic [COR_W-1:0] phcor_o,
    output logic             vld_o,
    output logic             start_o,
    output logic             sync_o,
    output logic             dcd_o
);
    localparam int DIF_W  = PHS_W + 1;
    localparam int HOLD_W = LOG_MAX + 1;

    win_cfg_t wcfg_q, wcfg_in;
    frm_cfg_t fcfg_q, fcfg_in;

    logic             cfg_wr, acc, trk_clr, vld_q;
    logic             mag_full, ph_rdy, cor_full;
    logic [PHS_W-1:0] ph_old, ph_step;
    logic [DIF_W-1:0] ph_abs;
    logic [LOG_MAX:0] fft_len, cp_len;

    assign wcfg_in = win_cfg_t'(cfg_data_i);
    assign fcfg_in = frm_cfg_t'(cfg_data_i);
    assign cfg_wr  = |cfg_we_i;
    assign acc     = vld_i & ~cfg_wr;
    assign trk_clr = init_i | cfg_wr;

    // configuration words with size clamping
    always_ff @(posedge clk) begin
        if (rst) begin
            wcfg_q <= '{fft_log: FLD_W'(4), cp_log: FLD_W'(2)};
            fcfg_q <= '{sof_dly: '0, sym_log: FLD_W'(5)};
        end else begin
            if (cfg_we_i[0]) begin
                wcfg_q.fft_log <= clamp_log(wcfg_in.fft_log, LOG_MAX);
                wcfg_q.cp_log  <= clamp_log(wcfg_in.cp_log, LOG_MAX);
            end
            if (cfg_we_i[1]) begin
                fcfg_q.sof_dly <= fcfg_in.sof_dly;
                fcfg_q.sym_log <= clamp_log(fcfg_in.sym_log, LOG_MAX);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= acc;
    end
    assign vld_o = vld_q;

    // magnitude over one symbol
    ofdm_win_avg #(.W(MAG_W), .LOG_MAX(LOG_MAX), .LW(FLD_W), .FRAC(0), .OUT_W(MAG_W)) u_mag (
        .clk(clk), .rst(rst), .clr(cfg_wr), .en(acc), .x(mag_i),
        .log_len(fcfg_q.sym_log), .avg(rssi_o), .full(mag_full)
    );

    // phase one FFT length back
    assign fft_len = (LOG_MAX+1)'(1) << wcfg_q.fft_log;
    assign cp_len  = (LOG_MAX+1)'(1) << wcfg_q.cp_log;

    ofdm_dly_line #(.W(PHS_W), .LOG_D(LOG_MAX)) u_phs (
        .clk(clk), .rst(rst), .clr(cfg_wr), .en(acc),
        .din(phs_i), .lag(fft_len), .dout(ph_old), .ready(ph_rdy)
    );

    assign ph_step = phs_i - ph_old;
    assign ph_abs  = ph_step[PHS_W-1] ? (DIF_W'(1) << PHS_W) - DIF_W'(ph_step)
                                      : DIF_W'(ph_step);

    // absolute phase steps over the cyclic prefix
    ofdm_win_avg #(.W(DIF_W), .LOG_MAX(LOG_MAX), .LW(FLD_W), .FRAC(COR_FRAC), .OUT_W(COR_W)) u_cor (
        .clk(clk), .rst(rst), .clr(cfg_wr), .en(acc & ph_rdy), .x(ph_abs),
        .log_len(wcfg_q.cp_log), .avg(phcor_o), .full(cor_full)
    );

    assign dcd_o = mag_full & (rssi_o >= min_amp_i);

    ofdm_min_hold #(.VW(MAG_W), .CW(FLD_W)) u_null_trk (
        .clk(clk), .rst(rst), .clr(trk_clr), .eval(vld_q & mag_full),
        .val(rssi_o), .hold(fcfg_q.sof_dly), .flag(start_o)
    );

    ofdm_min_hold #(.VW(COR_W), .CW(HOLD_W)) u_tim_trk (
        .clk(clk), .rst(rst), .clr(trk_clr), .eval(vld_q & cor_full),
        .val(phcor_o), .hold(cp_len - 1'b1), .flag(sync_o)
    );
endmodule

// File: rtl/ofdm_sync_detect_chk.sv
module ofdm_sync_detect_chk #(
    parameter int MAG_W = 16,
    parameter int PHS_W = 8,
    parameter int COR_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [MAG_W-1:0] mag_i,
    input logic [PHS_W-1:0] phs_i,
    input logic             vld_i,
    input logic             init_i,
    input logic [15:0]      cfg_data_i,
    input logic [1:0]       cfg_we_i,
    input logic [MAG_W-1:0] min_amp_i,
    input logic [MAG_W-1:0] rssi_o,
    input logic [COR_W-1:0] phcor_o,
    input logic             vld_o,
    input logic             start_o,
    input logic             sync_o,
    input logic             dcd_o
);
    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && cfg_we_i == 2'b00) |=> vld_o);

    // R10
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);

    // R1
    avg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!vld_i && cfg_we_i == 2'b00) |=> ($stable(rssi_o) && $stable(phcor_o)));

    // R4
    dcd_thr_chk: assert property (@(posedge clk) disable iff (rst)
        dcd_o |-> (rssi_o >= min_amp_i));

    // R7
    init_clr_chk: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (!start_o && !sync_o));

    // R8
    cfg_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i != 2'b00) |=> (rssi_o == '0 && phcor_o == '0 && !start_o && !sync_o && !dcd_o));

    // R5
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_o) |-> $past(vld_o));

    // R6
    sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> $past(vld_o));
endmodule

bind ofdm_sync_detect ofdm_sync_detect_chk #(
    .MAG_W(MAG_W), .PHS_W(PHS_W), .COR_W(COR_W)
) u_chk (.*);

// File: tb/ofdm_sync_detect_tb.sv
module ofdm_sync_detect_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] mag_i, min_amp_i, cfg_data_i, rssi_o;
    logic [7:0]  phs_i;
    logic        vld_i, init_i, vld_o, start_o, sync_o, dcd_o;
    logic [1:0]  cfg_we_i;
    logic [11:0] phcor_o;

    always #5 clk = ~clk;

    ofdm_sync_detect u_dut (.*);

    // row: sym8 cp8 fft8 sof8 pat4 count16 threshold16
    localparam logic [67:0] VEC [6] = '{
        {8'd5, 8'd2,   8'd4, 8'd0,  4'd0, 16'd200, 16'd3000},
        {8'd3, 8'd0,   8'd0, 8'd1,  4'd2, 16'd150, 16'd30000},
        {8'd6, 8'd6,   8'd6, 8'd3,  4'd1, 16'd400, 16'd1000},
        {8'd4, 8'd3,   8'd5, 8'd10, 4'd1, 16'd300, 16'd1500},
        {8'd9, 8'd200, 8'd7, 8'd2,  4'd2, 16'd300, 16'd40000},
        {8'd2, 8'd1,   8'd3, 8'd0,  4'd3, 16'd120, 16'd65000}
    };

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int mag_h [4096];
    int phs_h [4096];
    int dif_h [4096];
    int s_min, s_cnt, c_min, c_cnt, last_rssi;
    bit s_arm, s_flg, c_arm, c_flg;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gen_mag(input int pat, input int k);
        case (pat)
            0: return (k * 37) & 65535;
            1: return (((k / 64) % 4) == 2) ? 20 + (k % 5) : 3000 + (k % 7) * 11;
            2: return ((k * 40503 + 12345) ^ (k >> 3)) & 65535;
            default: return 65535 - k;
        endcase
    endfunction

    function automatic int gen_phs(input int pat, input int k);
        case (pat)
            0: return (k * 3) & 255;
            1: return ((k % 64) * 97 + ((((k / 64) % 4) == 2) ? 50 : 0)) & 255;
            2: return ((k * 29) ^ (k >> 2)) & 255;
            default: return (k * 200 + (k % 3) * 16) & 255;
        endcase
    endfunction

    function automatic int clampv(input int v);
        return (v > 6) ? 6 : v;
    endfunction

    task automatic trk(input int v, input int hold, inout int mn, inout int cnt,
                       inout bit arm, inout bit flg);
        if (v < mn) begin
            mn = v; cnt = hold; arm = 1;
        end else if (arm) begin
            if (cnt == 0) begin flg = 1; arm = 0; end
            else cnt = cnt - 1;
        end
    endtask

    task automatic trk_reset();
        s_min = 65535; s_cnt = 0; s_arm = 0; s_flg = 0;
        c_min = 4095;  c_cnt = 0; c_arm = 0; c_flg = 0;
    endtask

    task automatic run(input logic [67:0] row, input bit do_cfg);
        int S, C, F, sof, pat, ns, thr, L, Lc, N, m, lo, sum, csum, e_rssi, e_phc;
        bit full, cfull;
        string tag;
        S = clampv(int'(row[67:60])); C = clampv(int'(row[59:52]));
        F = clampv(int'(row[51:44])); sof = int'(row[43:36]);
        pat = int'(row[35:32]); ns = int'(row[31:16]); thr = int'(row[15:0]);
        L = 1 << S; Lc = 1 << C; N = 1 << F; m = 0;
        tag = (row[67:60] > 6 || row[59:52] > 6 || row[51:44] > 6) ? "R8" : "R1";
        min_amp_i = 16'(thr);
        if (do_cfg) begin
            cfg_data_i = {row[51:44], row[59:52]}; cfg_we_i = 2'b01;
            @(negedge clk);
            cfg_data_i = {row[43:36], row[67:60]}; cfg_we_i = 2'b10;
            @(negedge clk);
            cfg_we_i = 2'b00;
            // R8: write empties windows and clears flags
            chk(rssi_o == 0 && phcor_o == 0 && !start_o && !sync_o && !dcd_o,
                "R8", "clear after write", int'(rssi_o) + int'(phcor_o), 0);
        end
        trk_reset();
        for (int k = 0; k < ns; k++) begin
            mag_h[k] = gen_mag(pat, k);
            phs_h[k] = gen_phs(pat, k);
            mag_i = 16'(mag_h[k]); phs_i = 8'(phs_h[k]); vld_i = 1'b1;
            @(negedge clk);
            vld_i = 1'b0;
            lo = (k + 1 > L) ? k + 1 - L : 0;
            sum = 0;
            for (int j = lo; j <= k; j++) sum += mag_h[j];
            e_rssi = sum >> S;
            full = (k + 1 >= L);
            if (k >= N) begin
                int d;
                d = (phs_h[k] - phs_h[k - N]) & 255;
                dif_h[m] = (d >= 128) ? 256 - d : d;
                m++;
            end
            lo = (m > Lc) ? m - Lc : 0;
            csum = 0;
            for (int j = lo; j < m; j++) csum += dif_h[j];
            e_phc = ((csum * 16) >> C) & 4095;
            cfull = (m >= Lc);
            chk(vld_o == 1'b1, "R10", "vld_o after sample", int'(vld_o), 1);
            chk(int'(rssi_o) == e_rssi, tag, "rssi_o", int'(rssi_o), e_rssi);
            chk(int'(phcor_o) == e_phc, (C == 0) ? "R2" : "R3", "phcor_o", int'(phcor_o), e_phc);
            chk(dcd_o == (full && e_rssi >= thr), "R4", "dcd_o", int'(dcd_o),
                int'(full && e_rssi >= thr));
            if (full)  trk(e_rssi, sof, s_min, s_cnt, s_arm, s_flg);
            if (cfull) trk(e_phc, Lc - 1, c_min, c_cnt, c_arm, c_flg);
            last_rssi = e_rssi;
            @(negedge clk);
            chk(vld_o == 1'b0, "R10", "vld_o idle", int'(vld_o), 0);
            chk(start_o == s_flg, "R5", "start_o", int'(start_o), int'(s_flg));
            chk(sync_o == c_flg, "R6", "sync_o", int'(sync_o), int'(c_flg));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vld_i = 1'b0; init_i = 1'b0; cfg_we_i = 2'b00;
        cfg_data_i = '0; mag_i = '0; phs_i = '0; min_amp_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(rssi_o == 0 && phcor_o == 0 && !vld_o && !start_o && !sync_o && !dcd_o,
            "R9", "reset outputs", int'(rssi_o) + int'(phcor_o), 0);

        // R9: first row runs on the reset-default configuration
        for (int r = 0; r < 6; r++) begin
            run(VEC[r], r != 0);
            if (r == 2) begin
                // R7: init clears flags, sums untouched
                chk(start_o || sync_o, "R7", "a flag set before init",
                    int'(start_o) + int'(sync_o), 1);
                init_i = 1'b1;
                @(negedge clk);
                init_i = 1'b0;
                chk(!start_o && !sync_o, "R7", "flags after init",
                    int'(start_o) + int'(sync_o), 0);
                chk(int'(rssi_o) == last_rssi, "R7", "rssi kept over init",
                    int'(rssi_o), last_rssi);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule